// File: doc/BRIEF.md
# DMX Frame Supervisor and Classifier

This block watches a decoded DMX512 receive stream at the frame level. A byte-level front end supplies a frame-start strobe with the first byte, a strobe for each data slot and an end-of-frame strobe. The supervisor sorts each frame by its first byte into null-start-code, alternate-start-code or RDM. It counts the slots of the current frame, and it records the first byte and slot count of the most recent alternate frame in a status register. RDM frames are dropped: they restart nothing and their slots are not counted.

A free-running timebase tick drives two timers. The first detects loss of signal when no usable frame has started for longer than a limit (1.25 s by default, with a 1 us tick). During loss it turns off the line driver enable. The first usable frame start restores the driver in the same clock cycle. The second timer enforces a minimum spacing between regenerated output frames (1205 ticks, about 1/830 s). It raises a one-cycle permit for each frame that may be sent on, so input streams slower than 830 frames per second pass through untouched and faster ones are thinned.

Top module: `dmx_frame_supervisor`

## Requirements
- R1: The first byte sampled with `sof_i` is classified as 0x00 → class 1 (null), 0xCC → class 3 (RDM), any other value → class 2 (alternate). `frame_class_o` shows the class from the clock after the start and holds it until the next start. Class 0 means no frame since reset.
- R2: Every frame start clears `slot_count_o` one clock later. Each `slot_i` pulse inside an open null or alternate frame raises it by one on the next clock. Slot pulses in an RDM frame, or after `eof_i` has closed the frame, leave it unchanged.
- R3: `slot_count_o` saturates at MAX_SLOTS (512 by default). Further slots in the same frame are dropped.
- R4: On `eof_i` of an open alternate frame, `asc_code_o` and `asc_slots_o` take that frame's first byte and final slot count on the next clock. End strobes of null or RDM frames, of frames already closed, or of frames cut short by a new start leave them unchanged. Both reset to 0.
- R5: `loss_o` is 1 from reset until the first usable (non-RDM) frame start. After such a start it rises one clock after the tick that makes the number of ticks since the start exceed LOSS_TICKS.
- R6: A non-RDM frame start drops `loss_o` and raises `drv_en_o` combinationally in the same cycle. An RDM start does neither. `drv_en_o` is always the inverse of `loss_o`.
- R7: `permit_o` pulses for one clock, the clock after a non-RDM frame start, when at least GAP_TICKS ticks have passed since the last permitted start, or when no start has been permitted since reset. Otherwise no pulse is raised. RDM starts never raise it.
- R8: Alternate frames follow the same rules as null frames for the loss timer and the output spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Timebase tick, one cycle per time unit |
| sof_i | input | 1 | Frame start strobe, first byte valid |
| start_code_i | input | 8 | First byte of the frame |
| slot_i | input | 1 | One data slot received |
| eof_i | input | 1 | Frame ended |
| frame_class_o | output | 2 | Class of latest frame (0 none, 1 null, 2 alternate, 3 RDM) |
| slot_count_o | output | $clog2(MAX_SLOTS+1) | Slots counted in the current or last frame |
| asc_code_o | output | 8 | First byte of last completed alternate frame |
| asc_slots_o | output | $clog2(MAX_SLOTS+1) | Slot count of last completed alternate frame |
| loss_o | output | 1 | Loss of signal |
| drv_en_o | output | 1 | Line driver enable |
| permit_o | output | 1 | One-cycle permit to regenerate the frame |

## Verification
The stream mixes null, several alternate and RDM first bytes with short, long and over-length slot runs. This separates correct classification and status capture from a design that records every frame or counts RDM slots. Bursts of frames spaced closer than the gap limit are followed by widely spaced ones, which shows whether frames are thinned only when they are too fast. Stray slot and end strobes between frames, and a frame cut short by a new start, show whether closed frames are left alone. A long silence followed by an RDM start and then a null start checks the loss threshold, that RDM cannot revive the driver, and the same-cycle release.

// File: rtl/dmxsup_pkg.sv
package dmxsup_pkg;

    localparam logic [7:0] SC_NULL = 8'h00;
    localparam logic [7:0] SC_RDM  = 8'hCC;

    typedef enum logic [1:0] {
        FC_NONE = 2'd0,
        FC_NULL = 2'd1,
        FC_ALT  = 2'd2,
        FC_RDM  = 2'd3
    } frame_class_e;

    // Per-frame header captured at frame start
    typedef struct packed {
        frame_class_e cls;
        logic [7:0]   code;
        logic         open;
    } frame_hdr_t;

    function automatic frame_class_e classify(input logic [7:0] sc);
        if (sc == SC_NULL)
            return FC_NULL;
        else if (sc == SC_RDM)
            return FC_RDM;
        else
            return FC_ALT;
    endfunction

    // A start that the timers act on: anything but RDM
    function automatic logic usable_start(input logic sof, input logic [7:0] sc);
        return sof && (sc != SC_RDM);
    endfunction

endpackage

// File: rtl/dmxsup_frame_track.sv
module dmxsup_frame_track
    import dmxsup_pkg::*;
#(
    parameter int MAX_SLOTS = 512,
    localparam int SW = $clog2(MAX_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof_i,
    input  logic [7:0]    start_code_i,
    input  logic          slot_i,
    input  logic          eof_i,
    output frame_class_e  cls_o,
    output logic [SW-1:0] count_o,
    output logic [7:0]    asc_code_o,
    output logic [SW-1:0] asc_slots_o
);

    localparam logic [SW-1:0] CAP = SW'(MAX_SLOTS);

    frame_hdr_t    hdr_q;
    logic [SW-1:0] cnt_q;
    logic [SW-1:0] cnt_nxt;
    logic          take_slot;
    logic [7:0]    info_code_q;
    logic [SW-1:0] info_slots_q;

    // Slots count only in an open frame that is not RDM
    assign take_slot = hdr_q.open && (hdr_q.cls != FC_RDM) && slot_i;

    always_comb begin
        cnt_nxt = cnt_q;
        if (take_slot && (cnt_q != CAP))
            cnt_nxt = cnt_q + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q.cls  <= FC_NONE;
            hdr_q.code <= 8'h00;
            hdr_q.open <= 1'b0;
            cnt_q      <= '0;
        end else if (sof_i) begin
            // A new start abandons any frame still open
            hdr_q.cls  <= classify(start_code_i);
            hdr_q.code <= start_code_i;
            hdr_q.open <= 1'b1;
            cnt_q      <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            if (eof_i)
                hdr_q.open <= 1'b0;
        end
    end

    // Status of the latest completed alternate frame
    always_ff @(posedge clk) begin
        if (rst) begin
            info_code_q  <= 8'h00;
            info_slots_q <= '0;
        end else if (!sof_i && eof_i && hdr_q.open && (hdr_q.cls == FC_ALT)) begin
            info_code_q  <= hdr_q.code;
            info_slots_q <= cnt_nxt;
        end
    end

    assign cls_o       = hdr_q.cls;
    assign count_o     = cnt_q;
    assign asc_code_o  = info_code_q;
    assign asc_slots_o = info_slots_q;

endmodule

// File: rtl/dmxsup_loss_timer.sv
module dmxsup_loss_timer #(
    parameter int LOSS_TICKS = 1250000,
    localparam int LW = $clog2(LOSS_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic start_i,
    output logic loss_o
);

    localparam logic [LW-1:0] LIMIT = LW'(LOSS_TICKS);

    logic [LW-1:0] age_q;
    logic          lost_q;

    // Counts ticks since the last usable start; stops once lost
    always_ff @(posedge clk) begin
        if (rst) begin
            age_q  <= '0;
            lost_q <= 1'b1;
        end else if (start_i) begin
            age_q  <= '0;
            lost_q <= 1'b0;
        end else if (tick_i && !lost_q) begin
            if (age_q == LIMIT)
                lost_q <= 1'b1;
            else
                age_q <= age_q + LW'(1);
        end
    end

    // Same-cycle release on a usable start
    assign loss_o = lost_q && !start_i;

endmodule

// File: rtl/dmxsup_rate_gate.sv
module dmxsup_rate_gate #(
    parameter int GAP_TICKS = 1205,
    localparam int GW = $clog2(GAP_TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic start_i,
    output logic permit_o
);

    localparam logic [GW-1:0] GAP = GW'(GAP_TICKS);

    logic [GW-1:0] since_q;
    logic          pass;
    logic          permit_q;

    assign pass = start_i && (since_q >= GAP);

    // Saturating tick count since the last permitted start
    always_ff @(posedge clk) begin
        if (rst) begin
            since_q  <= GAP;
            permit_q <= 1'b0;
        end else begin
            permit_q <= pass;
            if (pass)
                since_q <= '0;
            else if (tick_i && (since_q != GAP))
                since_q <= since_q + GW'(1);
        end
    end

    assign permit_o = permit_q;

endmodule

// File: rtl/dmx_frame_supervisor.sv
module dmx_frame_supervisor
    import dmxsup_pkg::*;
#(
    parameter int MAX_SLOTS  = 512,
    parameter int LOSS_TICKS = 1250000,
    parameter int GAP_TICKS  = 1205,
    localparam int SW = $clog2(MAX_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          sof_i,
    input  logic [7:0]    start_code_i,
    input  logic          slot_i,
    input  logic          eof_i,
    output logic [1:0]    frame_class_o,
    output logic [SW-1:0] slot_count_o,
    output logic [7:0]    asc_code_o,
    output logic [SW-1:0] asc_slots_o,
    output logic          loss_o,
    output logic          drv_en_o,
    output logic          permit_o
);

    logic         good_start;
    frame_class_e cls;
    logic         loss;

    assign good_start = usable_start(sof_i, start_code_i);

    dmxsup_frame_track #(.MAX_SLOTS(MAX_SLOTS)) u_track (
        .clk          (clk),
        .rst          (rst),
        .sof_i        (sof_i),
        .start_code_i (start_code_i),
        .slot_i       (slot_i),
        .eof_i        (eof_i),
        .cls_o        (cls),
        .count_o      (slot_count_o),
        .asc_code_o   (asc_code_o),
        .asc_slots_o  (asc_slots_o)
    );

    dmxsup_loss_timer #(.LOSS_TICKS(LOSS_TICKS)) u_loss (
        .clk     (clk),
        .rst     (rst),
        .tick_i  (tick_i),
        .start_i (good_start),
        .loss_o  (loss)
    );

    dmxsup_rate_gate #(.GAP_TICKS(GAP_TICKS)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .tick_i   (tick_i),
        .start_i  (good_start),
        .permit_o (permit_o)
    );

    assign frame_class_o = cls;
    assign loss_o        = loss;
    assign drv_en_o      = !loss;

endmodule

// File: rtl/dmxsup_checker.sv
module dmxsup_checker
    import dmxsup_pkg::*;
#(
    parameter int MAX_SLOTS = 512,
    localparam int SW = $clog2(MAX_SLOTS + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_i,
    input logic          sof_i,
    input logic [7:0]    start_code_i,
    input logic          eof_i,
    input logic [1:0]    frame_class_o,
    input logic [SW-1:0] slot_count_o,
    input logic [7:0]    asc_code_o,
    input logic [SW-1:0] asc_slots_o,
    input logic          loss_o,
    input logic          drv_en_o,
    input logic          permit_o
);

    // R1: class follows the sampled first byte
    a_r1_class: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> frame_class_o == 2'(classify($past(start_code_i))));

    // R2: every start clears the count
    a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
        sof_i |=> slot_count_o == '0);

    // R3: count never exceeds the cap
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        slot_count_o <= SW'(MAX_SLOTS));

    // R4: status only moves after an end strobe
    a_r4_status_hold: assert property (@(posedge clk) disable iff (rst)
        !eof_i |=> ($stable(asc_code_o) && $stable(asc_slots_o)));

    // R5: loss only appears after a tick
    a_r5_loss_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(loss_o) |-> $past(tick_i));

    // R6: usable start releases the driver in its own cycle
    a_r6_same_cycle: assert property (@(posedge clk) disable iff (rst)
        (sof_i && start_code_i != SC_RDM) |-> (!loss_o && drv_en_o));

    // R7: RDM never yields a permit
    a_r7_rdm_blocked: assert property (@(posedge clk) disable iff (rst)
        (sof_i && start_code_i == SC_RDM) |=> !permit_o);

    // R7: a permit is always one clock after a start
    a_r7_after_start: assert property (@(posedge clk) disable iff (rst)
        permit_o |-> $past(sof_i));

endmodule

bind dmx_frame_supervisor dmxsup_checker #(.MAX_SLOTS(MAX_SLOTS)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .sof_i         (sof_i),
    .start_code_i  (start_code_i),
    .eof_i         (eof_i),
    .frame_class_o (frame_class_o),
    .slot_count_o  (slot_count_o),
    .asc_code_o    (asc_code_o),
    .asc_slots_o   (asc_slots_o),
    .loss_o        (loss_o),
    .drv_en_o      (drv_en_o),
    .permit_o      (permit_o)
);

// File: tb/test_dmx_frame_supervisor.sv
module test_dmx_frame_supervisor;

    localparam int MAXS = 6;
    localparam int LOSS = 30;
    localparam int GAPT = 8;
    localparam int SW   = $clog2(MAXS + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tick = 1'b0;
    logic          tick_en = 1'b1;
    logic          sof = 1'b0;
    logic [7:0]    code = 8'h00;
    logic          slot = 1'b0;
    logic          eof = 1'b0;
    logic [1:0]    cls;
    logic [SW-1:0] cnt;
    logic [7:0]    acode;
    logic [SW-1:0] aslots;
    logic          loss, drv, permit;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dmx_frame_supervisor #(.MAX_SLOTS(MAXS), .LOSS_TICKS(LOSS), .GAP_TICKS(GAPT)) i_dmx_frame_supervisor (
        .clk(clk), .rst(rst), .tick_i(tick), .sof_i(sof), .start_code_i(code),
        .slot_i(slot), .eof_i(eof), .frame_class_o(cls), .slot_count_o(cnt),
        .asc_code_o(acode), .asc_slots_o(aslots), .loss_o(loss),
        .drv_en_o(drv), .permit_o(permit));

    task automatic chk(input string tag, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Tick every second cycle
    int tcyc = 0;
    always @(negedge clk) begin
        tcyc++;
        tick <= tick_en && (tcyc % 2 == 0);
    end

    // Behavioural reference
    int  m_class, m_slots, m_code, m_acode, m_aslots;
    bit  m_open, m_lost, m_permit;
    int  m_age, m_gap;

    always @(posedge clk) begin
        bit vs;
        vs = sof && (code != 8'hCC);
        if (rst) begin
            m_class = 0; m_slots = 0; m_code = 0; m_open = 0;
            m_acode = 0; m_aslots = 0;
            m_lost = 1; m_age = LOSS + 1;
            m_permit = 0; m_gap = 1000;
        end else begin
            if (vs) begin
                m_age = 0; m_lost = 0;
            end else if (tick && !m_lost) begin
                m_age++;
                if (m_age > LOSS) m_lost = 1;
            end
            m_permit = 0;
            if (vs && m_gap >= GAPT) begin
                m_permit = 1; m_gap = 0;
            end else if (tick) begin
                m_gap++;
            end
            if (sof) begin
                m_class = (code == 8'h00) ? 1 : (code == 8'hCC) ? 3 : 2;
                m_code = code; m_open = 1; m_slots = 0;
            end else begin
                if (m_open && m_class != 3 && slot && m_slots < MAXS) m_slots++;
                if (eof && m_open) begin
                    m_open = 0;
                    if (m_class == 2) begin
                        m_acode = m_code; m_aslots = m_slots;
                    end
                end
            end
        end
        #1;
        if (!rst) begin
            chk("R1 class", cls, m_class);
            chk("R2/R3 slot count", cnt, m_slots);
            chk("R4 asc code", acode, m_acode);
            chk("R4 asc slots", aslots, m_aslots);
            chk("R5/R8 loss", loss, (m_lost && !(sof && code != 8'hCC)) ? 1 : 0);
            chk("R6 driver", drv, (m_lost && !(sof && code != 8'hCC)) ? 0 : 1);
            chk("R7/R8 permit", permit, m_permit ? 1 : 0);
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame(input logic [7:0] c, input int n, input int sp, input bit close);
        @(negedge clk); sof = 1; code = c;
        @(negedge clk); sof = 0;
        for (int i = 0; i < n; i++) begin
            slot = 1; @(negedge clk); slot = 0;
            repeat (sp) @(negedge clk);
        end
        if (close) begin
            eof = 1; @(negedge clk); eof = 0;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst = 0;
        idle(4);
        // Reset state, directed
        chk("R1 reset class", cls, 0);
        chk("R5 reset loss", loss, 1);
        chk("R4 reset status", acode, 0);

        frame(8'h00, 3, 1, 1);  idle(20);
        frame(8'h17, 5, 0, 1);  idle(20);
        chk("R4 asc code 0x17", acode, 8'h17);
        chk("R4 asc slots 5", aslots, 5);
        frame(8'hCC, 4, 1, 1);  idle(20);
        chk("R2 rdm slots not counted", cnt, 0);
        frame(8'h42, 10, 0, 1); idle(20);
        chk("R3 saturated count", aslots, MAXS);

        // Fast burst: spacing below the gap limit
        for (int k = 0; k < 5; k++) frame(8'h00, 1, 0, 1);
        for (int k = 0; k < 3; k++) frame(8'h33, 2, 0, 1);
        idle(30);
        // Slow frames all pass
        for (int k = 0; k < 3; k++) begin
            frame(8'h00, 2, 0, 1); idle(20);
        end

        // Stray strobes with no open frame
        slot = 1; eof = 1; @(negedge clk); slot = 0; eof = 0;
        idle(3);
        chk("R4 stray eof ignored", aslots, 2);

        // Frame cut short by a new start
        frame(8'h55, 2, 0, 0);
        frame(8'h00, 2, 0, 1);
        idle(4);
        chk("R4 aborted frame not recorded", acode, 8'h33);

        // Silence until loss
        idle(80);
        chk("R5 loss after silence", loss, 1);
        @(negedge clk); sof = 1; code = 8'hCC;
        #1 chk("R6 rdm keeps loss", loss, 1);
        @(negedge clk); sof = 0;
        idle(3);
        @(negedge clk); sof = 1; code = 8'h00;
        #1;
        chk("R6 same-cycle loss release", loss, 0);
        chk("R6 same-cycle driver on", drv, 1);
        @(negedge clk); sof = 0;
        idle(10);
        // Alternate frame restarts the loss timer too
        idle(50);
        frame(8'hFF, 1, 0, 1);
        idle(40);
        chk("R8 alternate restarts timer", loss, 0);
        idle(40);
        frame(8'h01, 3, 2, 1);
        idle(10);
        // Timer paused case
        tick_en = 0; idle(20); tick_en = 1;
        idle(90);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule